// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matching Scheduler

This block decides, once per timeslot, which inputs of an N-by-N input-queued switch may send through the crossbar and to which output. Each input keeps one virtual queue per output, and the occupancy of those queues is presented as an N×N request matrix. On a start pulse the block captures that matrix. It then runs a fixed number of request-grant-accept rounds, one round per clock. The result is a one-to-one pairing of inputs to outputs.

In every round, each output that is still free looks at the still-free inputs that want it. It grants the first of them found by scanning from its grant pointer in rising index order, wrapping at N. Each input then accepts the first grant it holds, found by scanning from its accept pointer. Accepted pairs are frozen, and they drop out of the rounds that follow. Later rounds therefore fill the gaps that the earlier ones left, and the matching grows toward maximal.

The pointers advance only for pairs accepted in the first round. A granting output moves its pointer to one past the input it served, and an accepting input moves its pointer to one past the output it took. This rotation spreads service fairly over successive timeslots. When the last round is done, a one-cycle done strobe is raised. The per-input match vector then holds steady until the next start.

Top module: `xbar_rr_sched`

## Requirements
- R1: Bit i*N_PORTS+j of `req_i` set means input i has traffic for output j. The matrix is captured on the cycle `start_i` is high, and changes to `req_i` after that cycle have no effect on the result of that timeslot.
- R2: An output grants only an input that requests it, and only while both that input and that output are still unmatched.
- R3: In each round, each free output grants at most one input: the first requesting free input at or after its grant pointer, scanning in rising index order modulo N_PORTS.
- R4: In each round, each input accepts at most one grant: the first granting output at or after its accept pointer, scanning in rising index order modulo N_PORTS.
- R5: The final matching is one-to-one, so no two valid inputs report the same output.
- R6: A pair accepted in one round is kept, and its input and output take no part in later rounds. Unmatched ports are paired in later rounds, up to ITERS rounds in all.
- R7: Pointers change only for pairs accepted in the first round. The grant pointer of output j becomes (i+1) mod N_PORTS, and the accept pointer of input i becomes (j+1) mod N_PORTS.
- R8: `done_o` is high for exactly one cycle, ITERS clock edges after the edge that samples `start_i`.
- R9: `match_valid_o` bit i marks input i as matched, and `match_port_o[i*IDX_W +: IDX_W]` gives its output index (0 when unmatched). Both are cleared by the edge that samples `start_i`, and they hold from `done_o` until the next start.
- R10: Reset clears `done_o`, `match_valid_o`, `match_port_o` and every grant and accept pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Capture the request matrix and begin a timeslot |
| req_i | input | N_PORTS*N_PORTS | Request matrix, bit i*N_PORTS+j = input i wants output j |
| match_valid_o | output | N_PORTS | Per-input matched flag |
| match_port_o | output | N_PORTS*IDX_W | Per-input output index, field i at bits i*IDX_W upward |
| done_o | output | 1 | One-cycle strobe after the last round |

## Verification
Some properties are checked by assertions on every cycle. These are: grant and accept vectors are one-hot or empty and lie inside their request sets, the matched inputs never share an output, the done strobe never lasts two cycles, the pointers move only on first-round acceptances, and the results are stable while idle. Other behaviour can only be shown by the bench's scenarios. This covers the actual choice made by the rotating pointers over successive timeslots, including wrap-around of the pointers. It also covers the matching growing over rounds, the exact done latency, requests being ignored after capture, and pointers returning to zero after reset.

// File: rtl/xbs_pkg.sv
// Shared helpers for the crossbar matching scheduler.
// Assumes index values are below the port count passed in.
package xbs_pkg;

    // Advance a ring index by one, wrapping at n.
    function automatic int unsigned ring_next(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/xbs_rr_pick.sv
// Rotating-priority picker: selects the first set request at or after
// the pointer, scanning upward with wrap-around.
// Assumes ptr < N. Purely combinational apart from its checks.
module xbs_rr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);

    int unsigned pos;

    // Scan from the pointer and take the first requester.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        pos = 0;
        for (int k = 0; k < N; k++) begin
            pos = 32'(ptr) + 32'(k);
            if (pos >= 32'(N)) pos = pos - 32'(N);
            if (!any && req[IW'(pos)]) begin
                any          = 1'b1;
                gnt[IW'(pos)] = 1'b1;
                idx          = IW'(pos);
            end
        end
    end

    // R3 / R4: at most one winner per pick.
    p_pick_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R2: the winner is always a requester.
    p_pick_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    // R4: any request yields a winner.
    p_pick_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> any);

endmodule

// File: rtl/xbs_grant_stage.sv
// Grant phase: every output picks one free requesting input.
// Assumes req is indexed [input][output]. The result is indexed
// [output][input].
module xbs_grant_stage #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0][N-1:0]   req,
    input  logic [N-1:0]          in_free,
    input  logic [N-1:0]          out_free,
    input  logic [N-1:0][IW-1:0]  gptr,
    output logic [N-1:0][N-1:0]   gnt_by_out
);

    logic [N-1:0][N-1:0]  col_req;
    logic [N-1:0][IW-1:0] col_idx;
    logic [N-1:0]         col_any;

    for (genvar j = 0; j < N; j++) begin : g_out
        // Gather the requests aimed at output j from free inputs.
        always_comb begin
            for (int i = 0; i < N; i++)
                col_req[j][i] = req[i][j] & in_free[i] & out_free[j];
        end

        xbs_rr_pick #(.N(N)) u_pick (
            .clk (clk),
            .rst_n (rst_n),
            .req (col_req[j]),
            .ptr (gptr[j]),
            .gnt (gnt_by_out[j]),
            .idx (col_idx[j]),
            .any (col_any[j])
        );

        // R2: a grant goes only to a free input from a free output.
        p_grant_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
            col_any[j] |-> (in_free[col_idx[j]] && out_free[j] && req[col_idx[j]][j]));
    end

endmodule

// File: rtl/xbs_accept_stage.sv
// Accept phase: every input picks one of the grants it received.
// Assumes gnt_by_out is indexed [output][input].
module xbs_accept_stage #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0][N-1:0]   gnt_by_out,
    input  logic [N-1:0][IW-1:0]  aptr,
    output logic [N-1:0]          acc_valid,
    output logic [N-1:0][IW-1:0]  acc_idx
);

    logic [N-1:0][N-1:0] row_gnt;
    logic [N-1:0][N-1:0] row_acc;

    for (genvar i = 0; i < N; i++) begin : g_in
        // Transpose: grants that reached input i.
        always_comb begin
            for (int j = 0; j < N; j++)
                row_gnt[i][j] = gnt_by_out[j][i];
        end

        xbs_rr_pick #(.N(N)) u_pick (
            .clk (clk),
            .rst_n (rst_n),
            .req (row_gnt[i]),
            .ptr (aptr[i]),
            .gnt (row_acc[i]),
            .idx (acc_idx[i]),
            .any (acc_valid[i])
        );

        // R4: an accepted output really granted this input.
        p_accept_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid[i] |-> (row_acc[i][acc_idx[i]] && gnt_by_out[acc_idx[i]][i]));
    end

endmodule

// File: rtl/xbar_rr_sched.sv
// Iterative round-robin crossbar matching scheduler.
// Captures an N x N request matrix on start_i and runs ITERS
// request-grant-accept rounds, one per clock. It then strobes done_o
// and holds the matching. Assumes N_PORTS >= 2 and ITERS >= 1.
// A start while busy restarts the timeslot.
module xbar_rr_sched #(
    parameter int N_PORTS = 4,
    parameter int ITERS   = 3,
    localparam int IDX_W  = $clog2(N_PORTS),
    localparam int CNT_W  = $clog2(ITERS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [N_PORTS*N_PORTS-1:0]   req_i,
    output logic [N_PORTS-1:0]           match_valid_o,
    output logic [N_PORTS*IDX_W-1:0]     match_port_o,
    output logic                         done_o
);
    import xbs_pkg::*;

    logic                              busy_q;
    logic [CNT_W-1:0]                  iter_q;
    logic                              done_q;
    logic [N_PORTS-1:0][N_PORTS-1:0]   req_q;
    logic [N_PORTS-1:0]                in_used_q;
    logic [N_PORTS-1:0]                out_used_q;
    logic [N_PORTS-1:0][IDX_W-1:0]     map_q;
    logic [N_PORTS-1:0][IDX_W-1:0]     gptr_q;
    logic [N_PORTS-1:0][IDX_W-1:0]     aptr_q;

    logic [N_PORTS-1:0][N_PORTS-1:0]   gnt_by_out;
    logic [N_PORTS-1:0]                acc_valid;
    logic [N_PORTS-1:0][IDX_W-1:0]     acc_idx;
    logic                              last_round;
    logic                              first_round;

    assign last_round  = busy_q && (iter_q == CNT_W'(ITERS - 1));
    assign first_round = busy_q && (iter_q == '0);

    xbs_grant_stage #(.N(N_PORTS)) u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req_q),
        .in_free    (~in_used_q),
        .out_free   (~out_used_q),
        .gptr       (gptr_q),
        .gnt_by_out (gnt_by_out)
    );

    xbs_accept_stage #(.N(N_PORTS)) u_accept (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt_by_out (gnt_by_out),
        .aptr       (aptr_q),
        .acc_valid  (acc_valid),
        .acc_idx    (acc_idx)
    );

    // Sequencing: capture on start, count rounds, strobe done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            iter_q <= '0;
            done_q <= 1'b0;
            req_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                busy_q <= 1'b1;
                iter_q <= '0;
                req_q  <= req_i;
            end else if (busy_q) begin
                iter_q <= iter_q + CNT_W'(1);
                if (last_round) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Matching state: record accepted pairs, clear on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_used_q  <= '0;
            out_used_q <= '0;
            map_q      <= '0;
        end else if (start_i) begin
            in_used_q  <= '0;
            out_used_q <= '0;
            map_q      <= '0;
        end else if (busy_q) begin
            for (int i = 0; i < N_PORTS; i++) begin
                if (acc_valid[i]) begin
                    in_used_q[i]           <= 1'b1;
                    out_used_q[acc_idx[i]] <= 1'b1;
                    map_q[i]               <= acc_idx[i];
                end
            end
        end
    end

    // Pointer update: only for pairs accepted in the first round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gptr_q <= '0;
            aptr_q <= '0;
        end else if (!start_i && first_round) begin
            for (int i = 0; i < N_PORTS; i++) begin
                if (acc_valid[i]) begin
                    aptr_q[i]          <= IDX_W'(ring_next(32'(acc_idx[i]), N_PORTS));
                    gptr_q[acc_idx[i]] <= IDX_W'(ring_next(32'(i), N_PORTS));
                end
            end
        end
    end

    assign match_valid_o = in_used_q;
    assign match_port_o  = map_q;
    assign done_o        = done_q;

    // R5: no two matched inputs share an output.
    for (genvar a = 0; a < N_PORTS; a++) begin : g_pa
        for (genvar b = a + 1; b < N_PORTS; b++) begin : g_pb
            p_one_to_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_used_q[a] && in_used_q[b]) |-> (map_q[a] != map_q[b]));
        end
    end

    // R8: done is a single-cycle strobe.
    p_done_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R9: results hold while idle and no start arrives.
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start_i) |=> ($stable(map_q) && $stable(in_used_q)));

    // R7: pointers move only after a first-round cycle.
    p_ptr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || !first_round) |=> ($stable(gptr_q) && $stable(aptr_q)));

    // R6: a matched input stays matched until the next start.
    p_keep_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ((in_used_q & $past(in_used_q)) == $past(in_used_q)));

endmodule

// File: tb/xbar_rr_sched_test.sv
// Bench for xbar_rr_sched with default parameters (4 ports, 3 rounds).
module xbar_rr_sched_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NR = 3;
    localparam int NV = 10;

    // Hand-derived sequence from reset (all pointers 0). map: input0 in bits [1:0].
    localparam logic [15:0] V_REQ [NV] = '{16'hFFFF, 16'hFFFF, 16'h0000, 16'h4444, 16'h4444,
                                          16'h4444, 16'h4444, 16'h4444, 16'h000F, 16'h000F};
    localparam logic [3:0]  V_VAL [NV] = '{4'h7, 4'hF, 4'h0, 4'h1, 4'h2,
                                          4'h4, 4'h8, 4'h1, 4'h1, 4'h1};
    localparam logic [7:0]  V_MAP [NV] = '{8'h24, 8'hE1, 8'h00, 8'h02, 8'h08,
                                          8'h20, 8'h80, 8'h02, 8'h03, 8'h00};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] req_i = '0;
    logic [3:0]  match_valid_o;
    logic [7:0]  match_port_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    xbar_rr_sched #(.N_PORTS(NP), .ITERS(NR)) uut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .req_i (req_i),
        .match_valid_o (match_valid_o), .match_port_o (match_port_o), .done_o (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Run one timeslot; mid is driven on req_i after the capture cycle.
    task automatic run(input logic [15:0] r, input logic [15:0] mid,
                       output logic [3:0] v, output logic [7:0] m);
        int n;
        bit seen;
        @(negedge clk);
        req_i = r;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        req_i = mid;
        check(match_valid_o == 4'h0, "R9 cleared by start", match_valid_o, 0);
        n = 0;
        seen = 1'b0;
        while (!seen && n < NR + 4) begin
            @(negedge clk);
            n++;
            if (done_o) seen = 1'b1;
        end
        check(seen && n == NR, "R8 done latency", n, NR);
        v = match_valid_o;
        m = match_port_o;
        @(negedge clk);
        check(done_o == 1'b0, "R8 done one cycle", done_o, 0);
        for (int a = 0; a < NP; a++)
            for (int b = a + 1; b < NP; b++)
                if (v[a] && v[b])
                    check(m[a*2 +: 2] != m[b*2 +: 2], "R5 output shared", m[a*2 +: 2], -1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        logic [3:0] v;
        logic [7:0] m;
        repeat (3) @(negedge clk);
        // R10: reset state.
        check(done_o == 1'b0, "R10 done at reset", done_o, 0);
        check(match_valid_o == 4'h0, "R10 valid at reset", match_valid_o, 0);
        check(match_port_o == 8'h00, "R10 map at reset", match_port_o, 0);
        rst_n = 1'b1;

        // Table walk: R3 R4 R6 R7 (round-robin choice, growth, pointer rotation).
        for (int k = 0; k < NV; k++) begin
            run(V_REQ[k], V_REQ[k], v, m);
            check(v == V_VAL[k], $sformatf("R3/R6 vector %0d valid", k), v, V_VAL[k]);
            check(m == V_MAP[k], $sformatf("R4/R7 vector %0d map", k), m, V_MAP[k]);
        end

        // R1: requests changed after capture are ignored.
        run(16'h0001, 16'hFFFF, v, m);
        check(v == 4'h1, "R1 late request ignored valid", v, 1);
        check(m == 8'h00, "R1 late request ignored map", m, 0);

        // R9: outputs hold while idle despite new requests.
        req_i = 16'hA5A5;
        repeat (5) @(negedge clk);
        check(match_valid_o == 4'h1, "R9 hold valid", match_valid_o, 1);
        check(match_port_o == 8'h00, "R9 hold map", match_port_o, 0);
        check(done_o == 1'b0, "R8 no spurious done", done_o, 0);

        // R10: reset returns pointers to 0, so a full matrix repeats the first result.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(match_valid_o == 4'h0, "R10 valid after reset", match_valid_o, 0);
        rst_n = 1'b1;
        run(16'hFFFF, 16'hFFFF, v, m);
        check(v == 4'h7, "R10 pointers reset valid", v, 7);
        check(m == 8'h24, "R10 pointers reset map", m, 8'h24);

        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hang counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule